// File: doc/BRIEF.md
# Subcode Channel Serial Output Interface

This block accepts the 8-bit subcode symbol that the disc decoder delivers once per frame and lets an external host read it out one bit at a time. The host supplies its own read clock. The block synchronises that clock into the system clock domain and advances one channel bit on each rising edge it detects. The bits come out in channel order P, Q, R, S, T, U, V, W. After the eighth bit the data line rests at 0.

Each time a symbol becomes readable, a one-cycle frame-sync strobe is raised. A block-sync level marks the two sync symbols that open every 98-frame block. The symbol path is double-buffered. A frame that arrives while the host is still reading waits in a hold register, and the bits already being shifted are not disturbed. An overrun pulse reports that case.

The shifter is run by a three-state machine:
- IDLE: the state after reset.
- SHIFT: a symbol is being read.
- DRAINED: all eight bits have been read.

Its transitions are:
- IDLE→SHIFT (load): a frame strobe arrives.
- SHIFT→SHIFT (reload): the eighth read edge coincides with a strobe or with a waiting held symbol.
- SHIFT→DRAINED (finish): the eighth read edge arrives with nothing to load.
- DRAINED→SHIFT (load): a frame strobe arrives.

Top module: `subcode_serial_out`

## Requirements
- R1: Bit 7 of `sym_data` is channel P and bit 0 is channel W. When a symbol enters the shifter, P is on `pw_data` at once, and each following read edge presents the next channel in the order P, Q, R, S, T, U, V, W.
- R2: `rd_clk` passes through a two-stage synchroniser before edge detection. A rising edge of `rd_clk` advances `pw_data` by exactly one bit, on the third system clock edge after the rise, provided `rd_clk` stays high and low for at least 3 system clocks each.
- R3: After the eighth read edge, `pw_data` is 0 until the next symbol is loaded. Read edges that arrive while no symbol is being read have no effect on any output.
- R4: `frame_sync` is high for exactly one cycle, in the cycle in which a new symbol first appears on `pw_data`, and at no other time.
- R5: `block_sync` is set when a symbol flagged by `sym_is_s0` or `sym_is_s1` enters the shifter. It is cleared when an unflagged symbol enters, and is otherwise unchanged, so it spans the two sync frames of a block.
- R6: A strobe that arrives before all eight bits of the current symbol have been read stores the new symbol in the hold register. It leaves `pw_data`, `frame_sync` and `block_sync` untouched. The held symbol enters the shifter on the eighth read edge of the current symbol.
- R7: `overrun` pulses high for one cycle, the cycle after a strobe that arrives while a read is unfinished. It is low otherwise.
- R8: A strobe in the same cycle as the eighth read edge counts as arriving after the read. The new symbol is loaded straight into the shifter and `overrun` stays low.
- R9: During and after reset, `pw_data`, `frame_sync`, `block_sync` and `overrun` are 0 and the machine is IDLE.
- R10: When two strobes arrive during one unfinished read, the later symbol is the one read next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_valid | input | 1 | Frame strobe, one cycle per frame symbol |
| sym_data | input | 8 | Subcode symbol, bit 7 = P ... bit 0 = W |
| sym_is_s0 | input | 1 | Symbol is the first block sync symbol |
| sym_is_s1 | input | 1 | Symbol is the second block sync symbol |
| rd_clk | input | 1 | Host read clock, asynchronous |
| frame_sync | output | 1 | One-cycle pulse: new symbol readable |
| block_sync | output | 1 | High while a sync symbol is in the shifter |
| pw_data | output | 1 | Serial channel bit |
| overrun | output | 1 | One-cycle pulse: frame arrived during an unfinished read |

## Verification
The frame strobe and the detected eighth read edge can fall in the same system clock cycle. Then the state machine has to decide whether the strobe finds the shifter busy, which would buffer the symbol and raise overrun, or free, which loads the symbol directly. The bench provokes this by counting the synchroniser latency: it raises `rd_clk` and drives the strobe into exactly the cycle in which the eighth edge is consumed. It then judges that `overrun` stays low while `frame_sync` pulses, and that `pw_data` carries the new symbol's P bit. A second scenario places the strobe a few edges earlier, to show the buffered path and the overrun pulse by contrast.

// File: rtl/subcode_pkg.sv
`timescale 1ns/1ps
package subcode_pkg;

    // Shifter control states
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_SHIFT   = 2'd1,
        ST_DRAINED = 2'd2
    } shift_state_t;

endpackage

// File: rtl/subcode_rclk_sync.sv
`timescale 1ns/1ps
// Brings the host read clock into the system domain and flags its rising edge.
module subcode_rclk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_clk,
    output logic rise
);
    localparam int PIPE_W = STAGES + 1;

    logic [PIPE_W-1:0] pipe;

    generate
        if (STAGES < 2) begin : g_bad_depth
            initial $error("subcode_rclk_sync: STAGES must be at least 2");
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe <= '0;
        end else begin
            pipe <= {pipe[PIPE_W-2:0], rd_clk};
        end
    end

    assign rise = pipe[STAGES-1] & ~pipe[STAGES];
endmodule

// File: rtl/subcode_hold_buf.sv
`timescale 1ns/1ps
// Second stage of the double buffer: keeps a symbol that arrived mid-read.
module subcode_hold_buf #(
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [SYM_W-1:0] wr_data,
    input  logic             wr_sync,
    input  logic             clr,
    output logic [SYM_W-1:0] hold_data,
    output logic             hold_sync,
    output logic             pend
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_sync <= 1'b0;
            pend      <= 1'b0;
        end else if (wr) begin
            hold_data <= wr_data;
            hold_sync <= wr_sync;
            pend      <= 1'b1;
        end else if (clr) begin
            pend      <= 1'b0;
        end
    end
endmodule

// File: rtl/subcode_shift_fsm.sv
`timescale 1ns/1ps
// Shifter control: decides load source, shifts on read edges, drives outputs.
module subcode_shift_fsm
    import subcode_pkg::*;
#(
    parameter int SYM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strobe,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             sym_sync,
    input  logic             rise,
    input  logic             pend,
    input  logic [SYM_W-1:0] hold_data,
    input  logic             hold_sync,
    output logic             buf_wr,
    output logic             buf_clr,
    output logic             pw_data,
    output logic             frame_sync,
    output logic             block_sync,
    output logic             overrun,
    output shift_state_t     state
);
    localparam int CNT_W = (SYM_W > 1) ? $clog2(SYM_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SYM_W - 1);

    shift_state_t     state_nx;
    logic [SYM_W-1:0] shreg;
    logic [CNT_W-1:0] cnt;
    logic             done_now;
    logic             busy;
    logic             load_new;
    logic             load_hold;

    // Read bookkeeping for this cycle
    always_comb begin
        done_now  = (state == ST_SHIFT) && rise && (cnt == LAST);
        busy      = (state == ST_SHIFT) && !done_now;
        load_new  = strobe && !busy;
        load_hold = !strobe && done_now && pend;
        buf_wr    = strobe && busy;
        buf_clr   = load_new || load_hold;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (load_new) state_nx = ST_SHIFT;
            end
            ST_SHIFT: begin
                if (done_now && !(load_new || load_hold)) state_nx = ST_DRAINED;
            end
            ST_DRAINED: begin
                if (load_new) state_nx = ST_SHIFT;
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            cnt        <= '0;
            frame_sync <= 1'b0;
            block_sync <= 1'b0;
            overrun    <= 1'b0;
        end else begin
            frame_sync <= load_new || load_hold;
            overrun    <= buf_wr;
            if (load_new) begin
                shreg      <= sym_data;
                cnt        <= '0;
                block_sync <= sym_sync;
            end else if (load_hold) begin
                shreg      <= hold_data;
                cnt        <= '0;
                block_sync <= hold_sync;
            end else if ((state == ST_SHIFT) && rise) begin
                shreg <= {shreg[SYM_W-2:0], 1'b0};
                cnt   <= cnt + 1'b1;
            end
        end
    end

    assign pw_data = shreg[SYM_W-1];
endmodule

// File: rtl/subcode_serial_out.sv
`timescale 1ns/1ps
// Subcode channel serial output: double-buffered symbol, host-clocked shift-out.
module subcode_serial_out
    import subcode_pkg::*;
#(
    parameter int SYM_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sym_valid,
    input  logic [SYM_W-1:0] sym_data,
    input  logic             sym_is_s0,
    input  logic             sym_is_s1,
    input  logic             rd_clk,
    output logic             frame_sync,
    output logic             block_sync,
    output logic             pw_data,
    output logic             overrun
);
    logic             rd_rise;
    logic             sym_sync;
    logic             buf_wr;
    logic             buf_clr;
    logic [SYM_W-1:0] hold_data;
    logic             hold_sync;
    logic             pend;
    shift_state_t     fsm_state;

    assign sym_sync = sym_is_s0 | sym_is_s1;

    subcode_rclk_sync #(.STAGES(SYNC_STAGES)) i_rsync (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_clk (rd_clk),
        .rise   (rd_rise)
    );

    subcode_hold_buf #(.SYM_W(SYM_W)) i_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (buf_wr),
        .wr_data   (sym_data),
        .wr_sync   (sym_sync),
        .clr       (buf_clr),
        .hold_data (hold_data),
        .hold_sync (hold_sync),
        .pend      (pend)
    );

    subcode_shift_fsm #(.SYM_W(SYM_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .strobe     (sym_valid),
        .sym_data   (sym_data),
        .sym_sync   (sym_sync),
        .rise       (rd_rise),
        .pend       (pend),
        .hold_data  (hold_data),
        .hold_sync  (hold_sync),
        .buf_wr     (buf_wr),
        .buf_clr    (buf_clr),
        .pw_data    (pw_data),
        .frame_sync (frame_sync),
        .block_sync (block_sync),
        .overrun    (overrun),
        .state      (fsm_state)
    );
endmodule

// File: rtl/subcode_serial_out_chk.sv
`timescale 1ns/1ps
module subcode_serial_out_chk
    import subcode_pkg::*;
(
    input logic         clk,
    input logic         rst_n,
    input logic         sym_valid,
    input logic         rd_rise,
    input logic         frame_sync,
    input logic         block_sync,
    input logic         pw_data,
    input logic         overrun,
    input shift_state_t fsm_state
);
    // R4: frame strobe is a single-cycle pulse
    p_fsync_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |=> !frame_sync);

    // R4: a new symbol appears only after a strobe or a read edge
    p_fsync_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
        frame_sync |-> ($past(sym_valid) || $past(rd_rise)));

    // R3: nothing is driven while no symbol is being read
    p_zero_when_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_state != ST_SHIFT) |-> !pw_data);

    // R2: the data line moves only on a load or a read edge
    p_bit_moves_on_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pw_data) |-> (frame_sync || $past(rd_rise)));

    // R5: block sync changes only when a symbol enters the shifter
    p_bsync_on_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_sync |-> $stable(block_sync));

    // R7: overrun only after a strobe that met an unfinished read
    p_overrun_cause_r7: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> ($past(sym_valid) && $past(fsm_state) == ST_SHIFT));

    // R6: a buffered arrival never produces a frame strobe at the same time
    p_overrun_no_fsync_r6: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |-> !frame_sync);
endmodule

bind subcode_serial_out subcode_serial_out_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sym_valid  (sym_valid),
    .rd_rise    (rd_rise),
    .frame_sync (frame_sync),
    .block_sync (block_sync),
    .pw_data    (pw_data),
    .overrun    (overrun),
    .fsm_state  (fsm_state)
);

// File: tb/test_subcode_serial_out.sv
`timescale 1ns/1ps
module test_subcode_serial_out;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sym_valid = 1'b0;
    logic [7:0] sym_data = '0;
    logic       sym_is_s0 = 1'b0;
    logic       sym_is_s1 = 1'b0;
    logic       rd_clk = 1'b0;
    logic       frame_sync, block_sync, pw_data, overrun;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    subcode_serial_out i_subcode_serial_out (
        .clk(clk), .rst_n(rst_n), .sym_valid(sym_valid), .sym_data(sym_data),
        .sym_is_s0(sym_is_s0), .sym_is_s1(sym_is_s1), .rd_clk(rd_clk),
        .frame_sync(frame_sync), .block_sync(block_sync),
        .pw_data(pw_data), .overrun(overrun)
    );

    // {is_s0, is_s1, symbol}
    localparam logic [9:0] VEC [6] = '{
        {1'b1, 1'b0, 8'hA5},
        {1'b0, 1'b1, 8'h3C},
        {1'b0, 1'b0, 8'h00},
        {1'b0, 1'b0, 8'hFF},
        {1'b0, 1'b0, 8'h81},
        {1'b0, 1'b0, 8'h6E}
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic load_sym(input logic [7:0] d, input logic s0, input logic s1);
        sym_valid = 1'b1; sym_data = d; sym_is_s0 = s0; sym_is_s1 = s1;
        @(negedge clk);
        sym_valid = 1'b0; sym_is_s0 = 1'b0; sym_is_s1 = 1'b0;
    endtask

    task automatic rd_up();
        rd_clk = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_down();
        rd_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd_edge();
        rd_up();
        rd_down();
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        #400us;
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual=hung expected=done");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 pw_data in reset", pw_data, 0);
        check("R9 frame_sync in reset", frame_sync, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 block_sync after reset", block_sync, 0);
        check("R9 overrun after reset", overrun, 0);

        // R3: read edges with no symbol are ignored
        rd_up();
        check("R3 idle edge frame_sync", frame_sync, 0);
        check("R3 idle edge pw_data", pw_data, 0);
        rd_down();
        rd_edge();
        check("R3 idle edges pw_data", pw_data, 0);

        // Table walk: R1, R2, R3, R4, R5
        foreach (VEC[i]) begin
            load_sym(VEC[i][7:0], VEC[i][9], VEC[i][8]);
            check("R4 frame_sync on load", frame_sync, 1);
            check("R5 block_sync level", block_sync, VEC[i][9] | VEC[i][8]);
            check("R1 P bit at load", pw_data, VEC[i][7]);
            @(negedge clk);
            check("R4 frame_sync one cycle", frame_sync, 0);
            for (int k = 1; k < 8; k++) begin
                rd_edge();
                check("R2 next channel bit", pw_data, VEC[i][7-k]);
            end
            rd_edge();
            check("R3 zero after eighth bit", pw_data, 0);
            rd_edge();
            check("R3 extra edge ignored", pw_data, 0);
            check("R5 block_sync held", block_sync, VEC[i][9] | VEC[i][8]);
        end

        // R6, R7, R10: arrivals during an unfinished read
        load_sym(8'hC3, 1'b1, 1'b0);
        for (int k = 1; k < 4; k++) rd_edge();
        load_sym(8'h5A, 1'b0, 1'b0);
        check("R7 overrun pulse", overrun, 1);
        check("R6 no frame_sync on buffered arrival", frame_sync, 0);
        check("R6 current bit untouched", pw_data, 8'hC3 >> 4 & 1);
        check("R6 block_sync untouched", block_sync, 1);
        @(negedge clk);
        check("R7 overrun one cycle", overrun, 0);
        load_sym(8'h96, 1'b0, 1'b0);
        check("R10 second overrun", overrun, 1);
        for (int k = 4; k < 8; k++) begin
            rd_edge();
            check("R6 old symbol continues", pw_data, (8'hC3 >> (7-k)) & 1);
        end
        rd_up();
        check("R6 held symbol loads on eighth edge", frame_sync, 1);
        check("R10 later symbol wins P", pw_data, 1);
        check("R5 block_sync cleared", block_sync, 0);
        rd_down();
        for (int k = 1; k < 8; k++) begin
            rd_edge();
            check("R10 later symbol bits", pw_data, (8'h96 >> (7-k)) & 1);
        end
        rd_edge();
        check("R3 zero after held symbol", pw_data, 0);

        // R8: strobe in the same cycle as the eighth read edge
        load_sym(8'h0F, 1'b0, 1'b0);
        for (int k = 1; k < 8; k++) rd_edge();
        check("R8 last bit before boundary", pw_data, 1);
        rd_clk = 1'b1;
        @(negedge clk);
        @(negedge clk);
        sym_valid = 1'b1; sym_data = 8'hF0; sym_is_s1 = 1'b1;
        @(negedge clk);
        sym_valid = 1'b0; sym_is_s1 = 1'b0;
        check("R8 no overrun at boundary", overrun, 0);
        check("R8 frame_sync at boundary", frame_sync, 1);
        check("R8 new P bit at boundary", pw_data, 1);
        check("R5 block_sync from s1", block_sync, 1);
        rd_down();
        for (int k = 1; k < 8; k++) begin
            rd_edge();
            check("R8 new symbol bits", pw_data, (8'hF0 >> (7-k)) & 1);
        end
        rd_edge();
        check("R3 drained after boundary symbol", pw_data, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule